// File: doc/BRIEF.md
# Keypad Event Queue with Interrupt Flags

This block holds keypad events in a small circular queue until a host collects them over a command interface. Each event arrives as a key code and a pressed flag on a one-cycle push strobe. It is stored as one byte, with the pressed flag in the top bit. An accepted event raises the keypad interrupt flag. An event that finds the queue full raises a sticky overflow error instead, and the status error flag goes up with it.

The host has two ways to read. A consuming read first moves the head pointer forward and then returns the entry under the new head. Because of this, the entry at the head itself serves as the "last collected" slot, and a queue holding one event or none returns zero and stays as it is. A peek read takes a byte index, returns the entry that far past the head without changing anything, and returns zero for an index beyond the fill count. A configuration write empties the queue and clears the status flags.

Once the status error flag and the overflow error are both set, incoming events have no effect at all until one of them is cleared.

Top module: `key_event_fifo`

## Requirements
- R1: After reset the fill count is 0, the keypad interrupt flag, the status error flag and the overflow error are 0, and the read data is 0x00.
- R2: A stored event byte holds the key code in bits 6:0 and the pressed flag in bit 7 (1 = pressed, 0 = released).
- R3: An accepted event increments the fill count and sets the keypad interrupt flag on the next cycle.
- R4: An event that arrives while the fill count is 16 is discarded. It sets the overflow error and the status error flag, and the fill count does not rise.
- R5: While the status error flag and the overflow error are both set, an incoming event changes neither the fill count, the stored entries nor any flag.
- R6: A consuming read while the fill count is 0 or 1 returns 0x00 and leaves the count and the head unchanged.
- R7: A consuming read while the fill count is 2 or more advances the head by one, modulo 16. It decrements the count and returns, on the next cycle, the entry at the new head.
- R8: The peek output is combinational. It gives the entry at (head + index) mod 16 when the index is below the fill count, and 0x00 otherwise.
- R9: A configuration clear sets the head and the fill count to 0 and clears the keypad interrupt and status error flags. It leaves the overflow error as it was, and any push or consuming read in the same cycle is ignored.
- R10: An accepted event and a successful consuming read in the same cycle leave the fill count unchanged, and both act correctly. Whether a push is accepted is judged against the count before that cycle's read.
- R11: A status clear drops the keypad interrupt and status error flags, and an error clear drops the overflow error. A flag that is set in the same cycle stays set.
- R12: Head and write positions wrap from entry 15 to entry 0 with no loss of order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_valid | input | 1 | One-cycle strobe for an incoming key event |
| ev_key | input | 7 | Key code of the event |
| ev_pressed | input | 1 | 1 for a press, 0 for a release |
| pop_req | input | 1 | Consuming read request |
| peek_idx | input | 4 | Byte index for the peek read |
| cfg_clear | input | 1 | Configuration write: empties the queue and clears status flags |
| stat_clr | input | 1 | Clears the keypad interrupt and status error flags |
| err_clr | input | 1 | Clears the overflow error |
| count | output | 5 | Number of stored entries, 0 to 16 |
| rd_data | output | 8 | Result of the last consuming read |
| peek_data | output | 8 | Peek result for peek_idx |
| kp_irq | output | 1 | Keypad interrupt flag |
| stat_err | output | 1 | Status error flag |
| ovf_err | output | 1 | Sticky overflow error |

## Verification
The bench builds the block with its defaults: a depth of 16 and a 7-bit key code. With this depth the full queue, the overflow, the blocked state and several head wraps can all be reached within a few dozen pushes. Directed sequences cover the boundaries at counts 0, 1 and 16. A long pseudo-random phase then mixes pushes, reads and clears in the same cycle, with every peek index swept against a behavioural model.

// File: rtl/key_event_fifo.sv
module key_event_fifo #(
  parameter int DEPTH = 16,
  parameter int KEY_W = 7,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1,
  localparam int BYTE_W = KEY_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [KEY_W-1:0]  ev_key,
  input  logic              ev_pressed,
  input  logic              pop_req,
  input  logic [PTR_W-1:0]  peek_idx,
  input  logic              cfg_clear,
  input  logic              stat_clr,
  input  logic              err_clr,
  output logic [CNT_W-1:0]  count,
  output logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] peek_data,
  output logic              kp_irq,
  output logic              stat_err,
  output logic              ovf_err
);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  head;

  wire full     = (count == CNT_W'(DEPTH));
  wire blocked  = stat_err & ovf_err;
  wire push_ok  = ev_valid & ~cfg_clear & ~blocked & ~full;
  wire push_ovf = ev_valid & ~cfg_clear & ~blocked & full;
  wire pop_ok   = pop_req & ~cfg_clear & (count > CNT_W'(1));

  wire [PTR_W-1:0] tail      = head + count[PTR_W-1:0];
  wire [PTR_W-1:0] next_head = head + PTR_W'(1);
  wire [PTR_W-1:0] peek_pos  = head + peek_idx;

  assign peek_data = ({1'b0, peek_idx} < count) ? mem[peek_pos] : '0;

  always_ff @(posedge clk)
    if (push_ok) mem[tail] <= {ev_pressed, ev_key};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head     <= '0;
      count    <= '0;
      rd_data  <= '0;
      kp_irq   <= 1'b0;
      stat_err <= 1'b0;
      ovf_err  <= 1'b0;
    end else begin
      if (cfg_clear) begin
        head     <= '0;
        count    <= '0;
        kp_irq   <= 1'b0;
        stat_err <= 1'b0;
      end else begin
        if (pop_req) rd_data <= pop_ok ? mem[next_head] : '0;
        if (pop_ok) head <= next_head;
        case ({push_ok, pop_ok})
          2'b10:   count <= count + CNT_W'(1);
          2'b01:   count <= count - CNT_W'(1);
          default: count <= count;
        endcase
        if (push_ok)       kp_irq <= 1'b1;
        else if (stat_clr) kp_irq <= 1'b0;
        if (push_ovf)      stat_err <= 1'b1;
        else if (stat_clr) stat_err <= 1'b0;
      end
      if (push_ovf)     ovf_err <= 1'b1;
      else if (err_clr) ovf_err <= 1'b0;
    end
  end

endmodule

// File: rtl/key_event_fifo_chk.sv
module key_event_fifo_chk #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_valid,
  input logic             pop_req,
  input logic             cfg_clear,
  input logic             stat_clr,
  input logic [CNT_W-1:0] count,
  input logic [7:0]       rd_data,
  input logic             kp_irq,
  input logic             stat_err,
  input logic             ovf_err
);

  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  a_r3_push_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !cfg_clear && !(stat_err && ovf_err) && count < CNT_W'(DEPTH))
      |=> kp_irq);

  a_r4_full_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !cfg_clear && !pop_req && !(stat_err && ovf_err) && count == CNT_W'(DEPTH))
      |=> (ovf_err && stat_err && count == CNT_W'(DEPTH)));

  a_r5_blocked_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && stat_err && ovf_err && !pop_req && !cfg_clear && !stat_clr)
      |=> ($stable(count) && $stable(kp_irq)));

  a_r6_short_pop_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !cfg_clear && !ev_valid && count <= CNT_W'(1))
      |=> (rd_data == 8'h00 && $stable(count)));

  a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clear |=> (count == '0 && !kp_irq && !stat_err));

  a_r10_net_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && pop_req && !cfg_clear && !(stat_err && ovf_err)
       && count > CNT_W'(1) && count < CNT_W'(DEPTH))
      |=> $stable(count));

endmodule

bind key_event_fifo key_event_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .pop_req(pop_req),
  .cfg_clear(cfg_clear), .stat_clr(stat_clr), .count(count),
  .rd_data(rd_data), .kp_irq(kp_irq), .stat_err(stat_err), .ovf_err(ovf_err)
);

// File: tb/key_event_fifo_tb_top.sv
`timescale 1ns/1ps
module key_event_fifo_tb_top;
  localparam int D = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_valid = 0, ev_pressed = 0, pop_req = 0, cfg_clear = 0, stat_clr = 0, err_clr = 0;
  logic [6:0] ev_key = '0;
  logic [3:0] peek_idx = '0;
  logic [4:0] count;
  logic [7:0] rd_data, peek_data;
  logic kp_irq, stat_err, ovf_err;

  always #2 clk = ~clk;

  key_event_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_key(ev_key),
    .ev_pressed(ev_pressed), .pop_req(pop_req), .peek_idx(peek_idx),
    .cfg_clear(cfg_clear), .stat_clr(stat_clr), .err_clr(err_clr),
    .count(count), .rd_data(rd_data), .peek_data(peek_data),
    .kp_irq(kp_irq), .stat_err(stat_err), .ovf_err(ovf_err)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  int m [D];
  int st = 0, ln = 0, rd = 0;
  bit kp = 0, se = 0, ov = 0;

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    int pk;
    pk = peek_idx;
    chk(tag, "count", count, ln);
    chk(tag, "kp_irq", kp_irq, kp);
    chk(tag, "stat_err", stat_err, se);
    chk(tag, "ovf_err", ovf_err, ov);
    chk(tag, "rd_data", rd_data, rd);
    chk(tag, "peek_data", peek_data, (pk < ln) ? m[(st + pk) % D] : 0);
  endtask

  task automatic model_step();
    bit blk, acc, ovl, pok;
    if (cfg_clear) begin
      st = 0; ln = 0; kp = 0; se = 0;
      if (err_clr) ov = 0;
    end else begin
      blk = se && ov;
      acc = ev_valid && !blk && ln < D;
      ovl = ev_valid && !blk && ln == D;
      pok = pop_req && ln > 1;
      if (pop_req) rd = pok ? m[(st + 1) % D] : 0;
      if (acc) m[(st + ln) % D] = {ev_pressed, ev_key};
      if (pok) st = (st + 1) % D;
      ln = ln + int'(acc) - int'(pok);
      if (acc) kp = 1; else if (stat_clr) kp = 0;
      if (ovl) se = 1; else if (stat_clr) se = 0;
      if (ovl) ov = 1; else if (err_clr) ov = 0;
    end
  endtask

  task automatic cyc(string tag, logic ev, logic [6:0] key, logic pr, logic pop,
                     logic [3:0] pk, logic cfg, logic sc, logic ec);
    ev_valid = ev; ev_key = key; ev_pressed = pr; pop_req = pop;
    peek_idx = pk; cfg_clear = cfg; stat_clr = sc; err_clr = ec;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(string tag, logic [3:0] pk);
    cyc(tag, 0, 0, 0, 0, pk, 0, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < D; i++) m[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare("R1");

    // R2 R3: three events, varied press state
    cyc("R3", 1, 7'h3c, 1, 0, 0, 0, 0, 0);
    cyc("R2", 1, 7'h55, 0, 0, 0, 0, 0, 0);
    cyc("R2", 1, 7'h7f, 1, 0, 1, 0, 0, 0);
    for (int i = 0; i < 5; i++) idle("R8", 4'(i));
    // R7: consuming read returns second entry
    cyc("R7", 0, 0, 0, 1, 0, 0, 0, 0);
    cyc("R7", 0, 0, 0, 1, 1, 0, 0, 0);
    // R6: count now 1
    cyc("R6", 0, 0, 0, 1, 0, 0, 0, 0);
    // R11: status clear
    cyc("R11", 0, 0, 0, 0, 0, 0, 1, 0);
    // R11: set wins over clear
    cyc("R11", 1, 7'h11, 0, 0, 0, 0, 1, 0);
    // R9: clear with push and pop in same cycle
    cyc("R9", 1, 7'h22, 1, 1, 0, 1, 0, 0);
    cyc("R6", 0, 0, 0, 1, 0, 0, 0, 0);
    // R4: fill to full and overflow
    for (int i = 0; i < D; i++) cyc("R4", 1, 7'(i + 8'h40), 1'(i), 0, 4'(i), 0, 0, 0);
    cyc("R4", 1, 7'h01, 1, 0, 15, 0, 0, 0);
    // R5: blocked
    cyc("R5", 1, 7'h02, 1, 0, 15, 0, 0, 0);
    cyc("R5", 1, 7'h03, 0, 1, 14, 0, 0, 0);
    cyc("R5", 1, 7'h04, 0, 0, 14, 0, 0, 0);
    // R11: status clear unblocks; overflow error stays, next push lands
    cyc("R11", 0, 0, 0, 0, 0, 0, 1, 0);
    cyc("R11", 1, 7'h05, 1, 0, 15, 0, 0, 0);
    cyc("R4", 1, 7'h06, 1, 0, 15, 0, 0, 0);
    cyc("R11", 0, 0, 0, 0, 0, 0, 0, 1);
    // R10 R12: push+pop together, wrapping head
    for (int i = 0; i < 40; i++) cyc("R12", 1, 7'(i), 1'(i >> 1), 1, 4'(i), 0, 0, 0);
    for (int i = 0; i < D; i++) cyc("R10", 0, 0, 0, 1, 4'(i), 0, 0, 0);
    for (int i = 0; i < D; i++) idle("R8", 4'(i));
    // mixed pseudo-random phase
    begin
      int s = 32'h1234;
      for (int i = 0; i < 3000; i++) begin
        s = s * 1103515245 + 12345;
        cyc("R10", s[16] | s[17], s[24:18], s[25], s[26] & s[27], s[31:28],
            (s[15:8] == 8'h5a), (s[14:11] == 4'h3), (s[13:10] == 4'h9));
      end
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule